// File: doc/BRIEF.md
# Masked Vector Double-to-Unsigned-Word Truncating Converter

This block turns a vector of up to eight IEEE-754 double-precision numbers into unsigned 32-bit integers, always rounding toward zero. A vector-length select chooses whether 2, 4 or 8 lanes take part. A per-lane write mask decides which lanes take a fresh conversion. A lane whose mask bit is clear either keeps the caller's previous destination value or is cleared, depending on the mask mode. A broadcast option feeds the lowest source element to every lane.

Values that do not fit an unsigned 32-bit word become 0xFFFFFFFF and raise an invalid flag. Conversions that discard a fractional part raise an inexact flag. Both flags are sticky until a synchronous clear. The block registers its result and returns it one cycle after an accepted request.

Top module: `vcvt_trunc_u32`

## Requirements
- R1: A request with `in_valid` high is returned on `res_vec` with `out_valid` high exactly one clock later. `out_valid` is low in any cycle that follows a cycle without `in_valid`. `res_vec` holds its value when no request arrives.
- R2: `vlen_sel` encodes the active lane count: 0 gives 2 lanes, 1 gives 4 lanes, 2 and 3 both give 8 lanes. Result lane j is `res_vec[32j+31:32j]` and converts `src_vec[64j+63:64j]`.
- R3: A finite value at or above 1.0 and below 2^32 gives its integer part, truncated toward zero. The inexact flag is raised when a fractional part is discarded. Nonzero values strictly between -1.0 and 1.0, subnormals included, give 0 and raise inexact.
- R4: NaN, either infinity, any value of 2^32 or more, and any value of -1.0 or less give 0xFFFFFFFF and raise the invalid flag, without inexact.
- R5: Positive or negative zero gives 0 and raises no flag.
- R6: A lane inside the active length whose `lane_mask` bit is 1 takes the converted value. A mask of all ones behaves as unmasked conversion.
- R7: An active lane whose mask bit is 0 takes its `prev_dst` lane when `zero_mask` is 0, and becomes 0 when `zero_mask` is 1.
- R8: With `bcast` high, every written lane converts `src_vec[63:0]`, and the other source elements have no effect.
- R9: Result lanes at or above the active lane count are 0, whatever the mask, mask mode or `prev_dst`.
- R10: Only lanes that take a converted value can raise a flag. Masked-off lanes and lanes beyond the active length raise none.
- R11: `flag_invalid` and `flag_inexact` stay set until `flag_clr` is high at a clock edge. A request accepted at that same edge still sets the flags from its own lanes.
- R12: While `rst_n` is low at a clock edge, `out_valid`, `res_vec` and both flags become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 512 | Eight double-precision source elements |
| vlen_sel | input | 2 | Active lane count select |
| lane_mask | input | 8 | Per-lane write enables |
| zero_mask | input | 1 | 1: clear unwritten lanes, 0: merge from prev_dst |
| bcast | input | 1 | Use element 0 for every lane |
| prev_dst | input | 256 | Previous destination value for merging |
| flag_clr | input | 1 | Clears the sticky flags |
| out_valid | output | 1 | Result strobe |
| res_vec | output | 256 | Packed 32-bit results |
| flag_invalid | output | 1 | Sticky invalid flag |
| flag_inexact | output | 1 | Sticky inexact flag |

## Verification
The hardest case is showing that flags come only from written lanes. A masked-off or out-of-length lane that holds a NaN or a fractional value leaves no trace in the result vector, so its only visible effect would be a flag. The stimulus clears the flags first. It then fills the masked-off lanes, and the lanes beyond the active length, with NaN or fractional values, while the written lanes carry exact values. The flags must stay low. A broadcast case loads NaNs into the seven unused source elements for the same reason.

// File: rtl/vcvt_pkg.sv
// Shared constants and helpers for the vector truncating converter.
// Assumes the IEEE-754 binary64 source format throughout.
package vcvt_pkg;
    localparam int F64_W   = 64;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int EXP_BIAS = 1023;

    // Lane-count encodings of the vector-length select
    typedef enum logic [1:0] {
        VLEN_2  = 2'd0,
        VLEN_4  = 2'd1,
        VLEN_8  = 2'd2,
        VLEN_8X = 2'd3
    } vlen_e;

    // Number of active lanes for a given select value, capped at max_lanes
    function automatic int unsigned active_lanes(input logic [1:0] sel, input int unsigned max_lanes);
        int unsigned n;
        case (sel)
            VLEN_2:  n = 2;
            VLEN_4:  n = 4;
            default: n = 8;
        endcase
        return (n > max_lanes) ? max_lanes : n;
    endfunction
endpackage

// File: rtl/vcvt_lane_conv.sv
// Combinational binary64 to unsigned integer conversion, rounding toward zero.
// Assumes DST_W <= 52. Out-of-range values give all ones and raise invalid,
// discarded fraction bits raise inexact.
module vcvt_lane_conv #(
    parameter int DST_W = 32
) (
    input  logic [vcvt_pkg::F64_W-1:0] fp_in,
    output logic [DST_W-1:0]           int_out,
    output logic                       inv,
    output logic                       inx
);
    import vcvt_pkg::*;

    localparam int MANT_W  = FRAC_W + 1;
    localparam int SH_W    = $clog2(MANT_W + 1);
    localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(EXP_BIAS);
    localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(EXP_BIAS + DST_W);
    localparam logic [EXP_W-1:0] EXP_SH0 = EXP_W'(EXP_BIAS + FRAC_W);

    logic              sgn;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic [MANT_W-1:0] mant;
    logic [SH_W-1:0]   sh;
    logic [MANT_W-1:0] lost_mask;

    assign sgn       = fp_in[F64_W-1];
    assign expo      = fp_in[F64_W-2 -: EXP_W];
    assign frac      = fp_in[FRAC_W-1:0];
    assign mant      = {1'b1, frac};
    assign sh        = SH_W'(EXP_SH0 - expo);
    assign lost_mask = (MANT_W'(1) << sh) - MANT_W'(1);

    // Classify the input and produce value and flags
    always_comb begin
        int_out = '0;
        inv     = 1'b0;
        inx     = 1'b0;
        if (expo == '1) begin
            int_out = '1;
            inv     = 1'b1;
        end else if (expo == '0 && frac == '0) begin
            int_out = '0;
        end else if (expo < EXP_ONE) begin
            inx     = 1'b1;
        end else if (sgn || expo >= EXP_LIM) begin
            int_out = '1;
            inv     = 1'b1;
        end else begin
            int_out = DST_W'(mant >> sh);
            inx     = |(mant & lost_mask);
        end
    end
endmodule

// File: rtl/vcvt_lane_sel.sv
// Per-lane output selection: converted value, merged previous value or zero.
// Assumes the caller decides whether the lane lies inside the active length.
// Flags pass through only for lanes that are written.
module vcvt_lane_sel #(
    parameter int DST_W = 32
) (
    input  logic             active,
    input  logic             wr_en,
    input  logic             zero_mode,
    input  logic [DST_W-1:0] conv_val,
    input  logic [DST_W-1:0] prev_val,
    input  logic             conv_inv,
    input  logic             conv_inx,
    output logic [DST_W-1:0] lane_val,
    output logic             lane_inv,
    output logic             lane_inx
);
    logic written;
    assign written = active & wr_en;

    // Choose the lane's result
    always_comb begin
        if (!active)        lane_val = '0;
        else if (wr_en)     lane_val = conv_val;
        else if (zero_mode) lane_val = '0;
        else                lane_val = prev_val;
    end

    assign lane_inv = written & conv_inv;
    assign lane_inx = written & conv_inx;
endmodule

// File: rtl/vcvt_flag_acc.sv
// Sticky exception flags. A clear drops the old state, but flags from a
// request accepted in the same cycle are still recorded.
module vcvt_flag_acc (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic inv_in,
    input  logic inx_in,
    output logic inv_q,
    output logic inx_q
);
    // Accumulate flags, synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q <= 1'b0;
            inx_q <= 1'b0;
        end else begin
            inv_q <= (inv_q & ~clr) | (upd & inv_in);
            inx_q <= (inx_q & ~clr) | (upd & inx_in);
        end
    end
endmodule

// File: rtl/vcvt_trunc_u32.sv
// Top: masked vector binary64 to unsigned 32-bit truncating converter.
// One register stage; results are held between requests. Assumes prev_dst
// is valid in the same cycle as in_valid.
module vcvt_trunc_u32 #(
    parameter int LANES = 8,
    parameter int DST_W = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [LANES*vcvt_pkg::F64_W-1:0]   src_vec,
    input  logic [1:0]                         vlen_sel,
    input  logic [LANES-1:0]                   lane_mask,
    input  logic                               zero_mask,
    input  logic                               bcast,
    input  logic [LANES*DST_W-1:0]             prev_dst,
    input  logic                               flag_clr,
    output logic                               out_valid,
    output logic [LANES*DST_W-1:0]             res_vec,
    output logic                               flag_invalid,
    output logic                               flag_inexact
);
    import vcvt_pkg::*;

    localparam int RES_W = LANES * DST_W;

    int unsigned            n_active;
    logic [RES_W-1:0]       res_d;
    logic [LANES-1:0]       inv_v;
    logic [LANES-1:0]       inx_v;

    assign n_active = active_lanes(vlen_sel, LANES);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [F64_W-1:0] elem;
        logic [DST_W-1:0] cval;
        logic             cinv;
        logic             cinx;

        assign elem = bcast ? src_vec[F64_W-1:0] : src_vec[j*F64_W +: F64_W];

        vcvt_lane_conv #(.DST_W(DST_W)) conv_i (
            .fp_in   (elem),
            .int_out (cval),
            .inv     (cinv),
            .inx     (cinx)
        );

        vcvt_lane_sel #(.DST_W(DST_W)) sel_i (
            .active    (j < n_active),
            .wr_en     (lane_mask[j]),
            .zero_mode (zero_mask),
            .conv_val  (cval),
            .prev_val  (prev_dst[j*DST_W +: DST_W]),
            .conv_inv  (cinv),
            .conv_inx  (cinx),
            .lane_val  (res_d[j*DST_W +: DST_W]),
            .lane_inv  (inv_v[j]),
            .lane_inx  (inx_v[j])
        );
    end

    // Result and valid register, synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) res_vec <= res_d;
        end
    end

    vcvt_flag_acc flags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (flag_clr),
        .upd    (in_valid),
        .inv_in (|inv_v),
        .inx_in (|inx_v),
        .inv_q  (flag_invalid),
        .inx_q  (flag_inexact)
    );
endmodule

// File: rtl/vcvt_trunc_u32_chk.sv
// Port-level protocol checks for vcvt_trunc_u32, bound to every instance.
module vcvt_trunc_u32_chk #(
    parameter int LANES = 8,
    parameter int DST_W = 32
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             in_valid,
    input logic [LANES*vcvt_pkg::F64_W-1:0] src_vec,
    input logic [1:0]                       vlen_sel,
    input logic [LANES-1:0]                 lane_mask,
    input logic                             zero_mask,
    input logic                             bcast,
    input logic [LANES*DST_W-1:0]           prev_dst,
    input logic                             flag_clr,
    input logic                             out_valid,
    input logic [LANES*DST_W-1:0]           res_vec,
    input logic                             flag_invalid,
    input logic                             flag_inexact
);
    localparam int RES_W = LANES * DST_W;

    p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_res_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_vec));
    p_merge_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !zero_mask && lane_mask == '0 && vlen_sel[1])
        |=> res_vec == $past(prev_dst));
    p_zero_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_mask && lane_mask == '0) |=> res_vec == '0);
    p_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mask == '0 && !flag_clr)
        |=> ($stable(flag_invalid) && $stable(flag_inexact)));
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'd0) |=> res_vec[RES_W-1:2*DST_W] == '0);
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_invalid && !flag_clr) |=> flag_invalid);
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !in_valid) |=> (!flag_invalid && !flag_inexact));
endmodule

bind vcvt_trunc_u32 vcvt_trunc_u32_chk #(.LANES(LANES), .DST_W(DST_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .src_vec      (src_vec),
    .vlen_sel     (vlen_sel),
    .lane_mask    (lane_mask),
    .zero_mask    (zero_mask),
    .bcast        (bcast),
    .prev_dst     (prev_dst),
    .flag_clr     (flag_clr),
    .out_valid    (out_valid),
    .res_vec      (res_vec),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact)
);

// File: tb/vcvt_trunc_u32_tb_top.sv
// Directed bench for vcvt_trunc_u32: one task per scenario.
module vcvt_trunc_u32_tb_top;
    localparam logic [63:0] D_ZERO  = 64'h0000000000000000;
    localparam logic [63:0] D_MZERO = 64'h8000000000000000;
    localparam logic [63:0] D_ONE   = 64'h3FF0000000000000;
    localparam logic [63:0] D_2P5   = 64'h4004000000000000;
    localparam logic [63:0] D_3     = 64'h4008000000000000;
    localparam logic [63:0] D_100   = 64'h4059000000000000;
    localparam logic [63:0] D_1E9   = 64'h41CDCD6500000000;
    localparam logic [63:0] D_MAX   = 64'h41EFFFFFFFE00000;
    localparam logic [63:0] D_2P32  = 64'h41F0000000000000;
    localparam logic [63:0] D_M1    = 64'hBFF0000000000000;
    localparam logic [63:0] D_MHALF = 64'hBFE0000000000000;
    localparam logic [63:0] D_0P75  = 64'h3FE8000000000000;
    localparam logic [63:0] D_SUB   = 64'h0000000000000001;
    localparam logic [63:0] D_NAN   = 64'h7FF8000000000000;
    localparam logic [63:0] D_PINF  = 64'h7FF0000000000000;
    localparam logic [63:0] D_NINF  = 64'hFFF0000000000000;
    localparam logic [31:0] ONES    = 32'hFFFFFFFF;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src_vec = '0;
    logic [1:0]   vlen_sel = 2'd2;
    logic [7:0]   lane_mask = '1;
    logic         zero_mask = 1'b0;
    logic         bcast = 1'b0;
    logic [255:0] prev_dst = '0;
    logic         flag_clr = 1'b0;
    logic         out_valid;
    logic [255:0] res_vec;
    logic         flag_invalid;
    logic         flag_inexact;

    logic [63:0]  vin [8];
    logic [31:0]  ex  [8];
    logic [255:0] prev_pat;
    int           n_tests = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    vcvt_trunc_u32 dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .vlen_sel(vlen_sel), .lane_mask(lane_mask), .zero_mask(zero_mask),
        .bcast(bcast), .prev_dst(prev_dst), .flag_clr(flag_clr),
        .out_valid(out_valid), .res_vec(res_vec),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exv);
        n_tests++;
        if (act !== exv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exv);
        end
    endtask

    function automatic logic [255:0] exp_vec();
        logic [255:0] v;
        for (int j = 0; j < 8; j++) v[32*j +: 32] = ex[j];
        return v;
    endfunction

    // One-cycle flag clear with no request
    task automatic clear_flags();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // Issue one request from vin and wait until its result is visible
    task automatic run(input logic [1:0] vl, input logic [7:0] m, input logic zm, input logic bc);
        @(negedge clk);
        for (int j = 0; j < 8; j++) src_vec[64*j +: 64] = vin[j];
        vlen_sel = vl; lane_mask = m; zero_mask = zm; bcast = bc;
        prev_dst = prev_pat; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 out_valid", 256'(out_valid), '0);
        chk("R12 res_vec", res_vec, '0);
        chk("R12 flags", 256'({flag_invalid, flag_inexact}), '0);
    endtask

    task automatic t_basic();
        clear_flags();
        vin = '{D_ONE, D_2P5, D_100, D_3, D_1E9, D_MAX, D_MZERO, D_0P75};
        ex  = '{32'd1, 32'd2, 32'd100, 32'd3, 32'h3B9ACA00, ONES, 32'd0, 32'd0};
        run(2'd2, 8'hFF, 1'b0, 1'b0);
        chk("R1 out_valid", 256'(out_valid), 256'(1));
        chk("R2 R3 R6 values", res_vec, exp_vec());
        chk("R3 inexact", 256'({flag_invalid, flag_inexact}), 256'(2'b01));
        @(negedge clk);
        chk("R1 valid drops", 256'(out_valid), '0);
        chk("R1 hold", res_vec, exp_vec());
    endtask

    task automatic t_exact();
        clear_flags();
        vin = '{D_ONE, D_3, D_100, D_MZERO, D_ZERO, D_1E9, D_MAX, D_ONE};
        ex  = '{32'd1, 32'd3, 32'd100, 32'd0, 32'd0, 32'h3B9ACA00, ONES, 32'd1};
        run(2'd3, 8'hFF, 1'b0, 1'b0);
        chk("R2 R5 exact values", res_vec, exp_vec());
        chk("R5 no flags", 256'({flag_invalid, flag_inexact}), '0);
    endtask

    task automatic t_invalid();
        clear_flags();
        vin = '{D_NAN, D_PINF, D_M1, D_2P32, D_MHALF, D_SUB, D_0P75, D_NINF};
        ex  = '{ONES, ONES, ONES, ONES, 32'd0, 32'd0, 32'd0, ONES};
        run(2'd2, 8'hFF, 1'b0, 1'b0);
        chk("R3 R4 mixed values", res_vec, exp_vec());
        chk("R3 R4 both flags", 256'({flag_invalid, flag_inexact}), 256'(2'b11));
        clear_flags();
        vin = '{D_NAN, D_PINF, D_M1, D_2P32, D_NINF, D_NAN, D_PINF, D_M1};
        ex  = '{ONES, ONES, ONES, ONES, ONES, ONES, ONES, ONES};
        run(2'd2, 8'hFF, 1'b0, 1'b0);
        chk("R4 saturate", res_vec, exp_vec());
        chk("R4 invalid only", 256'({flag_invalid, flag_inexact}), 256'(2'b10));
    endtask

    task automatic t_masking();
        for (int j = 0; j < 8; j++) prev_pat[32*j +: 32] = 32'hC0DE0000 + 32'(j);
        vin = '{D_ONE, D_2P5, D_100, D_3, D_1E9, D_MAX, D_MZERO, D_0P75};
        ex  = '{32'd1, 32'hC0DE0001, 32'd100, 32'hC0DE0003, 32'hC0DE0004, ONES, 32'hC0DE0006, 32'd0};
        run(2'd2, 8'hA5, 1'b0, 1'b0);
        chk("R7 merge", res_vec, exp_vec());
        ex  = '{32'd1, 32'd0, 32'd100, 32'd0, 32'd0, ONES, 32'd0, 32'd0};
        run(2'd2, 8'hA5, 1'b1, 1'b0);
        chk("R7 zeroing", res_vec, exp_vec());
    endtask

    task automatic t_length();
        vin = '{D_ONE, D_2P5, D_100, D_3, D_1E9, D_MAX, D_MZERO, D_0P75};
        ex  = '{32'd1, 32'd2, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0};
        run(2'd0, 8'hFF, 1'b0, 1'b0);
        chk("R9 two lanes merge", res_vec, exp_vec());
        ex  = '{32'd1, 32'd2, 32'd0, 32'd3, 32'd0, 32'd0, 32'd0, 32'd0};
        run(2'd1, 8'hFB, 1'b1, 1'b0);
        chk("R2 R9 four lanes", res_vec, exp_vec());
        prev_pat = '0;
    endtask

    task automatic t_bcast();
        clear_flags();
        vin = '{D_100, D_NAN, D_NAN, D_NAN, D_NAN, D_NAN, D_NAN, D_NAN};
        ex  = '{32'd100, 32'd100, 32'd100, 32'd100, 32'd100, 32'd100, 32'd100, 32'd100};
        run(2'd2, 8'hFF, 1'b0, 1'b1);
        chk("R8 broadcast", res_vec, exp_vec());
        chk("R8 no flags from others", 256'({flag_invalid, flag_inexact}), '0);
        ex  = '{32'd100, 32'd0, 32'd100, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0};
        run(2'd1, 8'h05, 1'b1, 1'b1);
        chk("R8 broadcast masked", res_vec, exp_vec());
    endtask

    task automatic t_flag_lanes();
        clear_flags();
        vin = '{D_ONE, D_NAN, D_2P5, D_NAN, D_0P75, D_PINF, D_2P5, D_NAN};
        ex  = '{32'd1, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0};
        run(2'd2, 8'h01, 1'b1, 1'b0);
        chk("R10 masked lanes value", res_vec, exp_vec());
        chk("R10 masked lanes flags", 256'({flag_invalid, flag_inexact}), '0);
        vin = '{D_ONE, D_3, D_NAN, D_2P5, D_NAN, D_0P75, D_NINF, D_2P5};
        ex  = '{32'd1, 32'd3, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0};
        run(2'd0, 8'hFF, 1'b0, 1'b0);
        chk("R10 short length value", res_vec, exp_vec());
        chk("R10 short length flags", 256'({flag_invalid, flag_inexact}), '0);
    endtask

    task automatic t_sticky();
        clear_flags();
        vin = '{D_NAN, D_ONE, D_ONE, D_ONE, D_ONE, D_ONE, D_ONE, D_ONE};
        run(2'd2, 8'hFF, 1'b0, 1'b0);
        vin = '{D_ONE, D_ONE, D_ONE, D_ONE, D_ONE, D_ONE, D_ONE, D_ONE};
        run(2'd2, 8'hFF, 1'b0, 1'b0);
        chk("R11 sticky", 256'({flag_invalid, flag_inexact}), 256'(2'b10));
        clear_flags();
        chk("R11 cleared", 256'({flag_invalid, flag_inexact}), '0);
        @(negedge clk);
        vin = '{D_2P5, D_ONE, D_ONE, D_ONE, D_ONE, D_ONE, D_ONE, D_ONE};
        flag_clr = 1'b1;
        run(2'd2, 8'hFF, 1'b0, 1'b0);
        flag_clr = 1'b0;
        chk("R11 clear with request", 256'({flag_invalid, flag_inexact}), 256'(2'b01));
    endtask

    initial begin
        prev_pat = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_exact();
        t_invalid();
        t_masking();
        t_length();
        t_bcast();
        t_flag_lanes();
        t_sticky();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule